// File: doc/BRIEF.md
# 8-bit Accumulator CPU Execute Stage

This block is the single-cycle execute step of a small 8-bit accumulator machine. Each cycle it takes an operation code that has already been decoded, the 8-bit memory operand and the present accumulator, index, stack and status values. It works out the new register set, the status byte, a write-back byte for stores and read-modify-write operations, and the branch decision. When the enable input is high, all results land in an output register on the rising clock edge. When enable is low, that register keeps its value.

The operation set covers several groups: bitwise combine, register load and store, status push/pull and single-flag set/clear, increment and decrement of memory or a register, and the four shift/rotate forms on a memory operand. It also carries the undocumented combined forms: shift-then-OR, shift-then-XOR, rotate-then-AND, rotate-only with carry update, AND-then-shift-right, AND with a fixed 0xEE mask, AND with carry copy, and the stack-AND that loads three registers at once. Fetch, addressing, bus timing, interrupts, stack pointer stepping and add/subtract are handled outside this block.

The datapath is split into three combinational pieces: a logic/load/flag unit, a shift unit and a branch evaluator. The top selects between them and holds the registered output stage. There is no sequencing state. The only storage is the output register, which has two conditions, loaded (enable high) and held (enable low).

Top module: `cpu8_exec_stage`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous) and in the cycle after it is released, a_out, x_out, y_out, s_out and wb_out read 0x00, p_out reads 0x20 and take_branch reads 0.
- R2: Outputs change only at a rising edge where en is 1. Results of the inputs at that edge appear on the outputs right after it. With en at 0, every output holds.
- R3: OR (code 3), AND (4) and XOR (5) combine the operand into A. Loads of A (6), X (7), Y (8), and of A and X together (9) copy the operand. Each sets N from bit 7 and Z from zero of the written value. C and V are unchanged. wb_out echoes the operand.
- R4: The store forms leave every register and the status byte unchanged and set wb_out: store A (11) gives A, store X (12) gives X, store Y (13) gives Y, store zero (14) gives 0x00, store A-and-X (15) gives A AND X.
- R5: Push status (16) gives wb_out = status OR 0x30. Pull status (10) loads the status from the operand. Clear C/I/V/D are codes 17/18/19/20 and set C/I/D are 21/22/23; each touches only its own bit.
- R6: Code 24 gives A = (A OR 0xEE) AND operand AND X. Code 25 gives A = A AND operand with C = new bit 7. Code 26 loads A, X and S with S AND operand. All three set N/Z from the new A.
- R7: Increment/decrement memory (27/28) writes the result to wb_out. Codes 29/30 step A, 31/32 step X and 33/34 step Y, wrapping modulo 256. All of them set N/Z from the result.
- R8: Shift left (35), rotate left (37), shift right (39) and rotate right (42) act on the operand and put the result on wb_out with N/Z from it. The bit shifted out goes to C. The rotates shift the old C in at the opposite end.
- R9: Shift-left-OR (36) and shift-right-XOR (40) shift the operand (bit out to C), write it back and fold it into A. Rotate-left-AND (38) rotates through C, writes back and ANDs into A. These three set N/Z from A. Rotate-right-keep (43) rotates right through C and writes back, leaving A, N and Z unchanged.
- R10: AND-shift-right (41) sets A = A AND operand, moves bit 0 of that value to C, shifts A right one place and sets N/Z from the result.
- R11: take_branch is 1 for: code 44 when N clear, 45 when N set, 46 when V clear, 47 when V set, 48 when C clear, 49 when C set, 50 when Z clear, 51 when Z set, and always for 52. It is 0 for every other code, and branch codes leave registers and status unchanged.
- R12: Idle (0), trap (1), halt (2) and every code above 52 leave A, X, Y, S and the status unchanged, echo the operand on wb_out and give take_branch 0.
- R13: The status byte has N at bit 7, V at 6, B at 4, D at 3, I at 2, Z at 1 and C at 0. Bit 5 of p_out always reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Capture results into the output register |
| op_code | input | 6 | Decoded operation code |
| operand_in | input | 8 | Memory operand byte |
| a_in | input | 8 | Current accumulator |
| x_in | input | 8 | Current X index |
| y_in | input | 8 | Current Y index |
| s_in | input | 8 | Current stack pointer |
| p_in | input | 8 | Current status byte |
| a_out | output | 8 | Updated accumulator |
| x_out | output | 8 | Updated X index |
| y_out | output | 8 | Updated Y index |
| s_out | output | 8 | Updated stack pointer |
| p_out | output | 8 | Updated status byte |
| wb_out | output | 8 | Byte to write back to memory |
| take_branch | output | 1 | Branch condition result |

## Verification
A wrong result from any unit shows up on the outputs just after the single enabled edge that captured it. A miscomputed carry or N/Z bit is visible in p_out in that same cycle, so no later stimulus is needed to expose it. A wrong choice between units, such as a branch code reaching the logic unit, shows up at once as a changed register or a spurious take_branch. A fault in the hold path only appears when en drops, so the bench changes the inputs while en is low and checks that the outputs stay put over several cycles.

// File: rtl/cpu8_exec_pkg.sv
package cpu8_exec_pkg;

    localparam int DW  = 8;
    localparam int OPW = 6;

    localparam logic [DW-1:0] MAGIC_MASK = 8'hEE;

    // status bit positions
    localparam int SB_N = 7;
    localparam int SB_V = 6;
    localparam int SB_1 = 5;
    localparam int SB_B = 4;
    localparam int SB_D = 3;
    localparam int SB_I = 2;
    localparam int SB_Z = 1;
    localparam int SB_C = 0;

    typedef enum logic [OPW-1:0] {
        OP_IDLE     = 6'd0,
        OP_TRAP     = 6'd1,
        OP_HALT     = 6'd2,
        OP_OR_A     = 6'd3,
        OP_AND_A    = 6'd4,
        OP_XOR_A    = 6'd5,
        OP_LD_A     = 6'd6,
        OP_LD_X     = 6'd7,
        OP_LD_Y     = 6'd8,
        OP_LD_AX    = 6'd9,
        OP_PULL_P   = 6'd10,
        OP_ST_A     = 6'd11,
        OP_ST_X     = 6'd12,
        OP_ST_Y     = 6'd13,
        OP_ST_ZERO  = 6'd14,
        OP_ST_AX    = 6'd15,
        OP_PUSH_P   = 6'd16,
        OP_CLR_C    = 6'd17,
        OP_CLR_I    = 6'd18,
        OP_CLR_V    = 6'd19,
        OP_CLR_D    = 6'd20,
        OP_SET_C    = 6'd21,
        OP_SET_I    = 6'd22,
        OP_SET_D    = 6'd23,
        OP_MASK_AND = 6'd24,
        OP_AND_CY   = 6'd25,
        OP_AND_S    = 6'd26,
        OP_INC_M    = 6'd27,
        OP_DEC_M    = 6'd28,
        OP_INC_A    = 6'd29,
        OP_DEC_A    = 6'd30,
        OP_INC_X    = 6'd31,
        OP_DEC_X    = 6'd32,
        OP_INC_Y    = 6'd33,
        OP_DEC_Y    = 6'd34,
        OP_SHL_M    = 6'd35,
        OP_SHL_OR   = 6'd36,
        OP_ROL_M    = 6'd37,
        OP_ROL_AND  = 6'd38,
        OP_SHR_M    = 6'd39,
        OP_SHR_XOR  = 6'd40,
        OP_AND_SHR  = 6'd41,
        OP_ROR_M    = 6'd42,
        OP_ROR_KEEP = 6'd43,
        OP_BR_NCLR  = 6'd44,
        OP_BR_NSET  = 6'd45,
        OP_BR_VCLR  = 6'd46,
        OP_BR_VSET  = 6'd47,
        OP_BR_CCLR  = 6'd48,
        OP_BR_CSET  = 6'd49,
        OP_BR_ZCLR  = 6'd50,
        OP_BR_ZSET  = 6'd51,
        OP_BR_ALL   = 6'd52
    } op_e;

    typedef struct packed {
        logic [DW-1:0] a;
        logic [DW-1:0] x;
        logic [DW-1:0] y;
        logic [DW-1:0] s;
        logic [DW-1:0] p;
        logic [DW-1:0] wb;
    } regset_t;

    // Return the status byte with N and Z taken from a result value
    function automatic logic [DW-1:0] with_nz(input logic [DW-1:0] st,
                                              input logic [DW-1:0] v);
        logic [DW-1:0] r;
        r       = st;
        r[SB_N] = v[DW-1];
        r[SB_Z] = (v == '0);
        return r;
    endfunction

endpackage

// File: rtl/cpu8_logic_unit.sv
module cpu8_logic_unit
    import cpu8_exec_pkg::*;
(
    input  op_e           op,
    input  logic [DW-1:0] opnd,
    input  regset_t       cur,
    output regset_t       res,
    output logic          hit
);

    always_comb begin
        res    = cur;
        res.wb = opnd;
        hit    = 1'b1;
        unique case (op)
            OP_OR_A:  begin res.a = cur.a | opnd; res.p = with_nz(cur.p, res.a); end
            OP_AND_A: begin res.a = cur.a & opnd; res.p = with_nz(cur.p, res.a); end
            OP_XOR_A: begin res.a = cur.a ^ opnd; res.p = with_nz(cur.p, res.a); end
            OP_LD_A:  begin res.a = opnd; res.p = with_nz(cur.p, opnd); end
            OP_LD_X:  begin res.x = opnd; res.p = with_nz(cur.p, opnd); end
            OP_LD_Y:  begin res.y = opnd; res.p = with_nz(cur.p, opnd); end
            OP_LD_AX: begin
                res.a = opnd;
                res.x = opnd;
                res.p = with_nz(cur.p, opnd);
            end
            OP_PULL_P:  res.p = opnd;
            OP_ST_A:    res.wb = cur.a;
            OP_ST_X:    res.wb = cur.x;
            OP_ST_Y:    res.wb = cur.y;
            OP_ST_ZERO: res.wb = '0;
            OP_ST_AX:   res.wb = cur.a & cur.x;
            OP_PUSH_P:  begin
                res.wb       = cur.p;
                res.wb[SB_B] = 1'b1;
                res.wb[SB_1] = 1'b1;
            end
            OP_CLR_C: res.p[SB_C] = 1'b0;
            OP_CLR_I: res.p[SB_I] = 1'b0;
            OP_CLR_V: res.p[SB_V] = 1'b0;
            OP_CLR_D: res.p[SB_D] = 1'b0;
            OP_SET_C: res.p[SB_C] = 1'b1;
            OP_SET_I: res.p[SB_I] = 1'b1;
            OP_SET_D: res.p[SB_D] = 1'b1;
            OP_MASK_AND: begin
                res.a = (cur.a | MAGIC_MASK) & opnd & cur.x;
                res.p = with_nz(cur.p, res.a);
            end
            OP_AND_CY: begin
                res.a       = cur.a & opnd;
                res.p       = with_nz(cur.p, res.a);
                res.p[SB_C] = res.a[DW-1];
            end
            OP_AND_S: begin
                res.a = cur.s & opnd;
                res.x = res.a;
                res.s = res.a;
                res.p = with_nz(cur.p, res.a);
            end
            OP_INC_M: begin res.wb = opnd + 1'b1;  res.p = with_nz(cur.p, res.wb); end
            OP_DEC_M: begin res.wb = opnd - 1'b1;  res.p = with_nz(cur.p, res.wb); end
            OP_INC_A: begin res.a = cur.a + 1'b1;  res.p = with_nz(cur.p, res.a); end
            OP_DEC_A: begin res.a = cur.a - 1'b1;  res.p = with_nz(cur.p, res.a); end
            OP_INC_X: begin res.x = cur.x + 1'b1;  res.p = with_nz(cur.p, res.x); end
            OP_DEC_X: begin res.x = cur.x - 1'b1;  res.p = with_nz(cur.p, res.x); end
            OP_INC_Y: begin res.y = cur.y + 1'b1;  res.p = with_nz(cur.p, res.y); end
            OP_DEC_Y: begin res.y = cur.y - 1'b1;  res.p = with_nz(cur.p, res.y); end
            default:  hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/cpu8_shift_unit.sv
module cpu8_shift_unit
    import cpu8_exec_pkg::*;
(
    input  op_e           op,
    input  logic [DW-1:0] opnd,
    input  regset_t       cur,
    output regset_t       res,
    output logic          hit
);

    logic          cin;
    logic [DW-1:0] shl_v;
    logic [DW-1:0] shr_v;
    logic [DW-1:0] rol_v;
    logic [DW-1:0] ror_v;
    logic [DW-1:0] and_v;

    assign cin   = cur.p[SB_C];
    assign shl_v = {opnd[DW-2:0], 1'b0};
    assign shr_v = {1'b0, opnd[DW-1:1]};
    assign rol_v = {opnd[DW-2:0], cin};
    assign ror_v = {cin, opnd[DW-1:1]};
    assign and_v = cur.a & opnd;

    always_comb begin
        res    = cur;
        res.wb = opnd;
        hit    = 1'b1;
        unique case (op)
            OP_SHL_M: begin
                res.wb = shl_v;
                res.p  = with_nz(cur.p, shl_v);
                res.p[SB_C] = opnd[DW-1];
            end
            OP_ROL_M: begin
                res.wb = rol_v;
                res.p  = with_nz(cur.p, rol_v);
                res.p[SB_C] = opnd[DW-1];
            end
            OP_SHR_M: begin
                res.wb = shr_v;
                res.p  = with_nz(cur.p, shr_v);
                res.p[SB_C] = opnd[0];
            end
            OP_ROR_M: begin
                res.wb = ror_v;
                res.p  = with_nz(cur.p, ror_v);
                res.p[SB_C] = opnd[0];
            end
            OP_SHL_OR: begin
                res.wb = shl_v;
                res.a  = cur.a | shl_v;
                res.p  = with_nz(cur.p, res.a);
                res.p[SB_C] = opnd[DW-1];
            end
            OP_SHR_XOR: begin
                res.wb = shr_v;
                res.a  = cur.a ^ shr_v;
                res.p  = with_nz(cur.p, res.a);
                res.p[SB_C] = opnd[0];
            end
            OP_ROL_AND: begin
                res.wb = rol_v;
                res.a  = cur.a & rol_v;
                res.p  = with_nz(cur.p, res.a);
                res.p[SB_C] = opnd[DW-1];
            end
            OP_ROR_KEEP: begin
                res.wb = ror_v;
                res.p[SB_C] = opnd[0];
            end
            OP_AND_SHR: begin
                res.a = {1'b0, and_v[DW-1:1]};
                res.p = with_nz(cur.p, res.a);
                res.p[SB_C] = and_v[0];
            end
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/cpu8_branch_eval.sv
module cpu8_branch_eval
    import cpu8_exec_pkg::*;
(
    input  op_e  op,
    input  logic flag_n,
    input  logic flag_v,
    input  logic flag_z,
    input  logic flag_c,
    output logic take,
    output logic hit
);

    always_comb begin
        take = 1'b0;
        hit  = 1'b1;
        unique case (op)
            OP_BR_NCLR: take = ~flag_n;
            OP_BR_NSET: take = flag_n;
            OP_BR_VCLR: take = ~flag_v;
            OP_BR_VSET: take = flag_v;
            OP_BR_CCLR: take = ~flag_c;
            OP_BR_CSET: take = flag_c;
            OP_BR_ZCLR: take = ~flag_z;
            OP_BR_ZSET: take = flag_z;
            OP_BR_ALL:  take = 1'b1;
            default:    hit  = 1'b0;
        endcase
    end

endmodule

// File: rtl/cpu8_exec_stage.sv
module cpu8_exec_stage
    import cpu8_exec_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [5:0]   op_code,
    input  logic [7:0]   operand_in,
    input  logic [7:0]   a_in,
    input  logic [7:0]   x_in,
    input  logic [7:0]   y_in,
    input  logic [7:0]   s_in,
    input  logic [7:0]   p_in,
    output logic [7:0]   a_out,
    output logic [7:0]   x_out,
    output logic [7:0]   y_out,
    output logic [7:0]   s_out,
    output logic [7:0]   p_out,
    output logic [7:0]   wb_out,
    output logic         take_branch
);

    op_e     op;
    regset_t cur;
    regset_t logic_res;
    regset_t shift_res;
    regset_t sel_res;
    logic    logic_hit;
    logic    shift_hit;
    logic    br_hit;
    logic    br_take;

    assign op  = op_e'(op_code);
    assign cur = '{a: a_in, x: x_in, y: y_in, s: s_in, p: p_in, wb: operand_in};

    cpu8_logic_unit u_logic (
        .op   (op),
        .opnd (operand_in),
        .cur  (cur),
        .res  (logic_res),
        .hit  (logic_hit)
    );

    cpu8_shift_unit u_shift (
        .op   (op),
        .opnd (operand_in),
        .cur  (cur),
        .res  (shift_res),
        .hit  (shift_hit)
    );

    cpu8_branch_eval u_branch (
        .op     (op),
        .flag_n (p_in[SB_N]),
        .flag_v (p_in[SB_V]),
        .flag_z (p_in[SB_Z]),
        .flag_c (p_in[SB_C]),
        .take   (br_take),
        .hit    (br_hit)
    );

    // Unit select: idle, trap, halt, branch and unknown codes pass through
    always_comb begin
        sel_res = cur;
        if (logic_hit)      sel_res = logic_res;
        else if (shift_hit) sel_res = shift_res;
    end

    // Output register: loaded when en is high, held otherwise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_out       <= '0;
            x_out       <= '0;
            y_out       <= '0;
            s_out       <= '0;
            p_out       <= 8'h20;
            wb_out      <= '0;
            take_branch <= 1'b0;
        end else if (en) begin
            a_out       <= sel_res.a;
            x_out       <= sel_res.x;
            y_out       <= sel_res.y;
            s_out       <= sel_res.s;
            p_out       <= sel_res.p | (8'h01 << SB_1);
            wb_out      <= sel_res.wb;
            take_branch <= br_hit & br_take;
        end
    end

    // R13
    status_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        p_out[SB_1] == 1'b1);

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en) |-> ($stable(a_out) && $stable(x_out) && $stable(y_out) &&
                        $stable(s_out) && $stable(p_out) && $stable(wb_out) &&
                        $stable(take_branch)));

    // R11
    branch_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && ($past(op_code) < 6'd44 || $past(op_code) > 6'd52))
            |-> !take_branch);

    // R12
    idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && $past(op_code) == 6'd0)
            |-> (a_out == $past(a_in) && x_out == $past(x_in) &&
                 y_out == $past(y_in) && s_out == $past(s_in) &&
                 wb_out == $past(operand_in)));

    // R4
    store_keeps_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && $past(op_code) >= 6'd11 && $past(op_code) <= 6'd15)
            |-> (a_out == $past(a_in) && x_out == $past(x_in) &&
                 p_out == ($past(p_in) | 8'h20)));

endmodule

// File: tb/cpu8_exec_stage_tb.sv
module cpu8_exec_stage_tb_top;

    typedef struct packed {
        logic [3:0] rq;
        logic [5:0] op;
        logic [7:0] m;
        logic [7:0] a;
        logic [7:0] x;
        logic [7:0] y;
        logic [7:0] s;
        logic [7:0] p;
        logic [7:0] ea;
        logic [7:0] ex;
        logic [7:0] ey;
        logic [7:0] es;
        logic [7:0] ep;
        logic [7:0] ew;
        logic       eb;
    } vec_t;

    localparam int NV = 58;

    // fields: req, op, operand, a, x, y, s, p | exp a, x, y, s, p, wb, branch
    localparam vec_t VT [0:NV-1] = '{
        // R3 combine and loads
        '{4'd3, 6'd3,  8'h81, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h20, 8'hDB, 8'h33, 8'h81, 8'hF0, 8'hA0, 8'h81, 1'b0},
        '{4'd3, 6'd4,  8'hA5, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h20, 8'h00, 8'h33, 8'h81, 8'hF0, 8'h22, 8'hA5, 1'b0},
        '{4'd3, 6'd5,  8'h5A, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'hA3, 8'h00, 8'h33, 8'h81, 8'hF0, 8'h23, 8'h5A, 1'b0},
        '{4'd3, 6'd7,  8'h80, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h20, 8'h5A, 8'h80, 8'h81, 8'hF0, 8'hA0, 8'h80, 1'b0},
        '{4'd3, 6'd9,  8'h7F, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h82, 8'h7F, 8'h7F, 8'h81, 8'hF0, 8'h20, 8'h7F, 1'b0},
        '{4'd3, 6'd8,  8'h00, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h20, 8'h5A, 8'h33, 8'h00, 8'hF0, 8'h22, 8'h00, 1'b0},
        '{4'd3, 6'd6,  8'hC4, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h22, 8'hC4, 8'h33, 8'h81, 8'hF0, 8'hA0, 8'hC4, 1'b0},
        // R4 stores
        '{4'd4, 6'd15, 8'h99, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h20, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h20, 8'h12, 1'b0},
        '{4'd4, 6'd14, 8'h99, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h20, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h20, 8'h00, 1'b0},
        '{4'd4, 6'd13, 8'h99, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h20, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h20, 8'h81, 1'b0},
        '{4'd4, 6'd11, 8'h99, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h20, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h20, 8'h5A, 1'b0},
        '{4'd4, 6'd12, 8'h99, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h20, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h20, 8'h33, 1'b0},
        // R5 status push/pull and flag set/clear
        '{4'd5, 6'd16, 8'h00, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'hC3, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'hE3, 8'hF3, 1'b0},
        '{4'd5, 6'd10, 8'h0F, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h20, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h2F, 8'h0F, 1'b0},
        '{4'd5, 6'd21, 8'h00, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h20, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h21, 8'h00, 1'b0},
        '{4'd5, 6'd18, 8'h00, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h24, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h20, 8'h00, 1'b0},
        '{4'd5, 6'd23, 8'h00, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h20, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h28, 8'h00, 1'b0},
        '{4'd5, 6'd19, 8'h00, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h60, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h20, 8'h00, 1'b0},
        '{4'd5, 6'd17, 8'h00, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h21, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h20, 8'h00, 1'b0},
        '{4'd5, 6'd22, 8'h00, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h20, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h24, 8'h00, 1'b0},
        '{4'd5, 6'd20, 8'h00, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h28, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h20, 8'h00, 1'b0},
        // R6 masked AND, AND with carry, stack AND
        '{4'd6, 6'd24, 8'hFF, 8'h11, 8'h33, 8'h81, 8'hF0, 8'h20, 8'h33, 8'h33, 8'h81, 8'hF0, 8'h20, 8'hFF, 1'b0},
        '{4'd6, 6'd25, 8'h8F, 8'hF0, 8'h33, 8'h81, 8'hF0, 8'h20, 8'h80, 8'h33, 8'h81, 8'hF0, 8'hA1, 8'h8F, 1'b0},
        '{4'd6, 6'd26, 8'h3C, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h20, 8'h30, 8'h30, 8'h81, 8'h30, 8'h20, 8'h3C, 1'b0},
        // R7 increment / decrement with wrap
        '{4'd7, 6'd27, 8'hFF, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h20, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h22, 8'h00, 1'b0},
        '{4'd7, 6'd32, 8'h00, 8'h5A, 8'h00, 8'h81, 8'hF0, 8'h20, 8'h5A, 8'hFF, 8'h81, 8'hF0, 8'hA0, 8'h00, 1'b0},
        '{4'd7, 6'd33, 8'h00, 8'h5A, 8'h33, 8'h7F, 8'hF0, 8'h20, 8'h5A, 8'h33, 8'h80, 8'hF0, 8'hA0, 8'h00, 1'b0},
        '{4'd7, 6'd28, 8'h01, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h20, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h22, 8'h00, 1'b0},
        '{4'd7, 6'd29, 8'h00, 8'hFF, 8'h33, 8'h81, 8'hF0, 8'h20, 8'h00, 8'h33, 8'h81, 8'hF0, 8'h22, 8'h00, 1'b0},
        '{4'd7, 6'd30, 8'h00, 8'h00, 8'h33, 8'h81, 8'hF0, 8'h20, 8'hFF, 8'h33, 8'h81, 8'hF0, 8'hA0, 8'h00, 1'b0},
        '{4'd7, 6'd31, 8'h00, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h20, 8'h5A, 8'h34, 8'h81, 8'hF0, 8'h20, 8'h00, 1'b0},
        '{4'd7, 6'd34, 8'h00, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h20, 8'h5A, 8'h33, 8'h80, 8'hF0, 8'hA0, 8'h00, 1'b0},
        // R8 shifts and rotates on the operand
        '{4'd8, 6'd35, 8'h81, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h20, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h21, 8'h02, 1'b0},
        '{4'd8, 6'd42, 8'h01, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h21, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'hA1, 8'h80, 1'b0},
        '{4'd8, 6'd37, 8'h80, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h20, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h23, 8'h00, 1'b0},
        '{4'd8, 6'd39, 8'h03, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h20, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h21, 8'h01, 1'b0},
        // R9 combined shift forms
        '{4'd9, 6'd36, 8'hC0, 8'h0F, 8'h33, 8'h81, 8'hF0, 8'h20, 8'h8F, 8'h33, 8'h81, 8'hF0, 8'hA1, 8'h80, 1'b0},
        '{4'd9, 6'd40, 8'h02, 8'h01, 8'h33, 8'h81, 8'hF0, 8'h20, 8'h00, 8'h33, 8'h81, 8'hF0, 8'h22, 8'h01, 1'b0},
        '{4'd9, 6'd38, 8'h40, 8'hFF, 8'h33, 8'h81, 8'hF0, 8'h21, 8'h81, 8'h33, 8'h81, 8'hF0, 8'hA0, 8'h81, 1'b0},
        '{4'd9, 6'd43, 8'h02, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'hA1, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'hA0, 8'h81, 1'b0},
        // R10 AND then shift right
        '{4'd10, 6'd41, 8'h03, 8'hFF, 8'h33, 8'h81, 8'hF0, 8'h20, 8'h01, 8'h33, 8'h81, 8'hF0, 8'h21, 8'h03, 1'b0},
        '{4'd10, 6'd41, 8'h80, 8'hF0, 8'h33, 8'h81, 8'hF0, 8'h21, 8'h40, 8'h33, 8'h81, 8'hF0, 8'h20, 8'h80, 1'b0},
        // R11 branch conditions
        '{4'd11, 6'd44, 8'h10, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h20, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h20, 8'h10, 1'b1},
        '{4'd11, 6'd44, 8'h10, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'hA0, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'hA0, 8'h10, 1'b0},
        '{4'd11, 6'd45, 8'h10, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'hA0, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'hA0, 8'h10, 1'b1},
        '{4'd11, 6'd46, 8'h10, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h60, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h60, 8'h10, 1'b0},
        '{4'd11, 6'd47, 8'h10, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h60, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h60, 8'h10, 1'b1},
        '{4'd11, 6'd48, 8'h10, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h21, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h21, 8'h10, 1'b0},
        '{4'd11, 6'd49, 8'h10, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h21, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h21, 8'h10, 1'b1},
        '{4'd11, 6'd50, 8'h10, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h22, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h22, 8'h10, 1'b0},
        '{4'd11, 6'd51, 8'h10, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h22, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h22, 8'h10, 1'b1},
        '{4'd11, 6'd52, 8'h10, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h20, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h20, 8'h10, 1'b1},
        // R12 idle, trap, halt, unknown codes
        '{4'd12, 6'd0,  8'h77, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'hCB, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'hEB, 8'h77, 1'b0},
        '{4'd12, 6'd1,  8'h77, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'hCB, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'hEB, 8'h77, 1'b0},
        '{4'd12, 6'd2,  8'h77, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'hCB, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'hEB, 8'h77, 1'b0},
        '{4'd12, 6'd60, 8'h77, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'hCB, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'hEB, 8'h77, 1'b0},
        '{4'd12, 6'd63, 8'h77, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'hCB, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'hEB, 8'h77, 1'b0},
        // R13 bit 5 forced even when pulled as zero
        '{4'd13, 6'd10, 8'h00, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'hFF, 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h20, 8'h00, 1'b0}
    };

    logic       clk;
    logic       rst_n;
    logic       en;
    logic [5:0] op_code;
    logic [7:0] operand_in, a_in, x_in, y_in, s_in, p_in;
    logic [7:0] a_out, x_out, y_out, s_out, p_out, wb_out;
    logic       take_branch;

    int  n_checks;
    int  n_fail;
    bit  done;

    cpu8_exec_stage dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .op_code     (op_code),
        .operand_in  (operand_in),
        .a_in        (a_in),
        .x_in        (x_in),
        .y_in        (y_in),
        .s_in        (s_in),
        .p_in        (p_in),
        .a_out       (a_out),
        .x_out       (x_out),
        .y_out       (y_out),
        .s_out       (s_out),
        .p_out       (p_out),
        .wb_out      (wb_out),
        .take_branch (take_branch)
    );

    // 125 MHz
    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic check_all(input int rq, input string what,
                             input logic [7:0] ea, input logic [7:0] ex,
                             input logic [7:0] ey, input logic [7:0] es,
                             input logic [7:0] ep, input logic [7:0] ew,
                             input logic eb);
        n_checks++;
        if (a_out !== ea || x_out !== ex || y_out !== ey || s_out !== es ||
            p_out !== ep || wb_out !== ew || take_branch !== eb) begin
            n_fail++;
            $display("FAIL R%0d %s: got a=%h x=%h y=%h s=%h p=%h wb=%h br=%b exp a=%h x=%h y=%h s=%h p=%h wb=%h br=%b",
                     rq, what, a_out, x_out, y_out, s_out, p_out, wb_out, take_branch,
                     ea, ex, ey, es, ep, ew, eb);
        end
    endtask

    task automatic drive(input vec_t v);
        op_code    = v.op;
        operand_in = v.m;
        a_in       = v.a;
        x_in       = v.x;
        y_in       = v.y;
        s_in       = v.s;
        p_in       = v.p;
    endtask

    initial begin
        n_checks = 0;
        n_fail   = 0;
        done     = 1'b0;
        rst_n    = 1'b0;
        en       = 1'b0;
        drive(VT[0]);

        // R1 reset state while held
        repeat (3) @(negedge clk);
        check_all(1, "in reset", 8'h00, 8'h00, 8'h00, 8'h00, 8'h20, 8'h00, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all(1, "after release, en low", 8'h00, 8'h00, 8'h00, 8'h00, 8'h20, 8'h00, 1'b0);

        // table walk: drive at negedge, capture at posedge, sample next negedge
        for (int i = 0; i < NV; i++) begin
            drive(VT[i]);
            en = 1'b1;
            @(negedge clk);
            en = 1'b0;
            check_all(VT[i].rq, $sformatf("vector %0d op %0d", i, VT[i].op),
                      VT[i].ea, VT[i].ex, VT[i].ey, VT[i].es,
                      VT[i].ep, VT[i].ew, VT[i].eb);
        end

        // R2 hold: load a known result, then change inputs with en low
        drive(VT[0]);
        en = 1'b1;
        @(negedge clk);
        en = 1'b0;
        drive(VT[51]);
        repeat (3) @(negedge clk);
        check_all(2, "hold with en low", 8'hDB, 8'h33, 8'h81, 8'hF0, 8'hA0, 8'h81, 1'b0);
        drive(VT[23]);
        @(negedge clk);
        check_all(2, "still held", 8'hDB, 8'h33, 8'h81, 8'hF0, 8'hA0, 8'h81, 1'b0);

        // R2 back-to-back enabled cycles each take effect
        drive(VT[51]);
        en = 1'b1;
        @(negedge clk);
        check_all(11, "first of pair", 8'h5A, 8'h33, 8'h81, 8'hF0, 8'h20, 8'h10, 1'b1);
        drive(VT[23]);
        @(negedge clk);
        en = 1'b0;
        check_all(6, "second of pair", 8'h30, 8'h30, 8'h81, 8'h30, 8'h20, 8'h3C, 1'b0);

        // R1 asynchronous reset mid-run
        #1 rst_n = 1'b0;
        #1;
        check_all(1, "async reset", 8'h00, 8'h00, 8'h00, 8'h00, 8'h20, 8'h00, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all(1, "post reset idle", 8'h00, 8'h00, 8'h00, 8'h00, 8'h20, 8'h00, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got running expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule